// File: doc/BRIEF.md
# Fractional Clock Divider Field Encoder

This block turns a clock divider ratio, given in eighths, into the packed 16-bit configuration words that a clock synthesizer's output counter expects. The ratio arrives as one scaled value: the upper bits hold the integer divider and the three low bits hold the fractional part in eighths. From this value the block derives the high and low counts, the odd-edge flag, and the no-count bypass. When a fraction is present it also derives the fractional enable, the two wave-shaping flags and the fractional phase. It emits three counter words and a power-mode word.

A new value is presented with a one-cycle valid strobe. One clock later the block registers the four words and pulses its own valid. The words then hold until the next accepted value. An integer divider outside the supported range does not change the words. It pulses an error output in the cycle where a valid would have appeared.

Top module: `fdivFieldEnc`

## Requirements
- R1: The input `divIn` is read as integer divider `divIn[10:3]` and fraction `divIn[2:0]`, both unsigned.
- R2: For integer divider 1, `wordCtrl` is 0x0040 (no-count flag at bit 6 only), and `wordHiLo` and `wordPhase` are 0, whatever the fraction.
- R3: For integer divider N ≥ 2 with zero fraction: high = N/2 (rounded down), edge = N mod 2, low = N − high. The fraction enable, both wave flags and the phase are 0.
- R4: For integer divider N ≥ 2 with a non-zero fraction F: the fraction enable is 1, the frac field equals F, high starts at N/2, edge = N mod 2, and low starts equal to high.
- R5: In fractional mode with edge 0, high is reduced by one and the rising wave flag is 1. With edge 1 the rising wave flag is 0. Low is reduced by one when edge is 0 or F is 1.
- R6: In fractional mode the falling wave flag is 1 when (edge is 0) XOR (F is 1), or when N is 2 and F is 1. The phase equals edge·4 + F/2 (rounded down).
- R7: Field positions. `wordHiLo` = high[5:0] at bits 11:6 and low[5:0] at bits 5:0. `wordCtrl` = frac at 14:12, fraction enable at 11, rising wave flag at 10, edge at 7, no-count at 6. `wordPhase` = phase at 13:11, falling wave flag at 10. All other bits are 0.
- R8: `wordPower` is 0x9800 when the fraction bits are non-zero and 0x0000 otherwise.
- R9: High and low are written modulo 64, so a count of 64 is encoded as 0.
- R10: An input with integer divider 0 or above 128 pulses `errOut` for one cycle, one clock later. No `outValid` is given, and all four words keep their previous values.
- R11: `outValid` pulses for exactly one cycle, one clock after an accepted `inValid`. The words hold their values until the next accepted input. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe marking `divIn` as a new value |
| divIn | input | 11 | Divider ratio in eighths |
| outValid | output | 1 | One-cycle pulse when new words are loaded |
| errOut | output | 1 | One-cycle pulse when an input was rejected |
| wordHiLo | output | 16 | High/low count word |
| wordCtrl | output | 16 | Control word (frac, enable, flags, edge, no-count) |
| wordPhase | output | 16 | Fractional phase word |
| wordPower | output | 16 | Power-mode word |

## Verification
Every result is due one clock edge after the edge that sees `inValid`. That applies to the four words, the `outValid` pulse and the `errOut` pulse. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the loading edge. One cycle later it confirms that the pulse is gone. After idle gaps of random length it checks that the words still hold the last accepted result. After each rejected input it compares the words against the previously expected values.

// File: rtl/fdiv_enc_pkg.sv
package fdiv_enc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch freshly computed words
    logic reject;   // input out of range, words untouched
  } ctlStrb_t;

  // Control word bit positions
  localparam int unsigned POS_FRAC  = 12;
  localparam int unsigned POS_FEN   = 11;
  localparam int unsigned POS_WFR   = 10;
  localparam int unsigned POS_EDGE  = 7;
  localparam int unsigned POS_NOCNT = 6;
  // Phase word bit positions
  localparam int unsigned POS_PHASE = 11;
  localparam int unsigned POS_WFF   = 10;
  // Power word used when a fraction is present
  localparam logic [15:0] POWER_FRAC = 16'h9800;

endpackage

// File: rtl/fdivFieldCalc.sv
module fdivFieldCalc #(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 3
) (
  input  logic [INT_W-1:0]  intPart,
  input  logic [FRAC_W-1:0] fracPart,
  output logic [INT_W-1:0]  hiCnt,
  output logic [INT_W-1:0]  loCnt,
  output logic              edgeBit,
  output logic              noCount,
  output logic              fracEn,
  output logic              wfRise,
  output logic              wfFall,
  output logic [FRAC_W-1:0] phase
);

  logic fracIsOne;
  logic fracZero;
  logic divIsOne;
  logic divIsTwo;

  assign fracIsOne = (fracPart == FRAC_W'(1));
  assign fracZero  = (fracPart == '0);
  assign divIsOne  = (intPart == INT_W'(1));
  assign divIsTwo  = (intPart == INT_W'(2));

  always_comb begin
    hiCnt   = '0;
    loCnt   = '0;
    edgeBit = 1'b0;
    noCount = 1'b0;
    fracEn  = 1'b0;
    wfRise  = 1'b0;
    wfFall  = 1'b0;
    phase   = '0;
    if (divIsOne) begin
      noCount = 1'b1;
    end else if (fracZero) begin
      hiCnt   = intPart >> 1;
      edgeBit = intPart[0];
      loCnt   = intPart - hiCnt;
    end else begin
      fracEn  = 1'b1;
      hiCnt   = intPart >> 1;
      edgeBit = intPart[0];
      loCnt   = hiCnt;
      if (!edgeBit) begin
        hiCnt  = hiCnt - INT_W'(1);
        wfRise = 1'b1;
      end
      if (!edgeBit || fracIsOne) begin
        loCnt = loCnt - INT_W'(1);
      end
      wfFall = ((!edgeBit) ^ fracIsOne) || (divIsTwo && fracIsOne);
      phase  = {edgeBit, fracPart[FRAC_W-1:1]};
    end
  end

endmodule

// File: rtl/fdivEncCtrl.sv
module fdivEncCtrl
  import fdiv_enc_pkg::*;
#(
  parameter int unsigned INT_W   = 8,
  parameter int unsigned MAX_DIV = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [INT_W-1:0] intPart,
  output ctlStrb_t         strb,
  output logic             outValid,
  output logic             errOut
);

  localparam logic [INT_W-1:0] DIV_LIMIT = INT_W'(MAX_DIV);

  logic inRange;

  assign inRange     = (intPart != '0) && (intPart <= DIV_LIMIT);
  assign strb.load   = inValid && inRange;
  assign strb.reject = inValid && !inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      errOut   <= 1'b0;
    end else begin
      outValid <= strb.load;
      errOut   <= strb.reject;
    end
  end

  // R11: an accepted input gives a valid on the next edge
  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && intPart != '0 && intPart <= DIV_LIMIT) |=> (outValid && !errOut));

  // R10: a rejected input gives an error on the next edge
  assert_err_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (intPart == '0 || intPart > DIV_LIMIT)) |=> (errOut && !outValid));

  // R11: no pulse without a strobe
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && !errOut);

endmodule

// File: rtl/fdivEncPath.sv
module fdivEncPath
  import fdiv_enc_pkg::*;
#(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 3,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrb_t                  strb,
  input  logic [INT_W+FRAC_W-1:0]   divIn,
  output logic [WORD_W-1:0]         wordHiLo,
  output logic [WORD_W-1:0]         wordCtrl,
  output logic [WORD_W-1:0]         wordPhase,
  output logic [WORD_W-1:0]         wordPower
);

  logic [INT_W-1:0]  intPart;
  logic [FRAC_W-1:0] fracPart;
  logic [INT_W-1:0]  hiCnt;
  logic [INT_W-1:0]  loCnt;
  logic              edgeBit;
  logic              noCount;
  logic              fracEn;
  logic              wfRise;
  logic              wfFall;
  logic [FRAC_W-1:0] phase;

  logic [WORD_W-1:0] hiLoNext;
  logic [WORD_W-1:0] ctrlNext;
  logic [WORD_W-1:0] phaseNext;
  logic [WORD_W-1:0] powerNext;

  assign intPart  = divIn[FRAC_W +: INT_W];
  assign fracPart = divIn[FRAC_W-1:0];

  fdivFieldCalc #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
  ) uCalc (
    .intPart (intPart),
    .fracPart(fracPart),
    .hiCnt   (hiCnt),
    .loCnt   (loCnt),
    .edgeBit (edgeBit),
    .noCount (noCount),
    .fracEn  (fracEn),
    .wfRise  (wfRise),
    .wfFall  (wfFall),
    .phase   (phase)
  );

  // Pack the fields; counts wrap modulo 2**CNT_W
  always_comb begin
    hiLoNext                   = '0;
    hiLoNext[CNT_W +: CNT_W]   = CNT_W'(hiCnt);
    hiLoNext[0 +: CNT_W]       = CNT_W'(loCnt);

    ctrlNext                   = '0;
    ctrlNext[POS_FRAC +: FRAC_W] = fracEn ? fracPart : '0;
    ctrlNext[POS_FEN]          = fracEn;
    ctrlNext[POS_WFR]          = wfRise;
    ctrlNext[POS_EDGE]         = edgeBit;
    ctrlNext[POS_NOCNT]        = noCount;

    phaseNext                  = '0;
    phaseNext[POS_PHASE +: FRAC_W] = phase;
    phaseNext[POS_WFF]         = wfFall;

    powerNext = (fracPart != '0) ? WORD_W'(POWER_FRAC) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordHiLo  <= '0;
      wordCtrl  <= '0;
      wordPhase <= '0;
      wordPower <= '0;
    end else if (strb.load) begin
      wordHiLo  <= hiLoNext;
      wordCtrl  <= ctrlNext;
      wordPhase <= phaseNext;
      wordPower <= powerNext;
    end
  end

  // R10 / R11: words change only when a load is strobed
  assert_words_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(wordHiLo) && $stable(wordCtrl) &&
                    $stable(wordPhase) && $stable(wordPower)));

  // R2: bypass leaves counts, phase and fraction enable clear
  assert_nocount_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    wordCtrl[POS_NOCNT] |-> (wordHiLo == '0 && wordPhase == '0 && !wordCtrl[POS_FEN]));

  // R5: rising wave flag follows even edge in fractional mode
  assert_wave_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordCtrl[POS_FEN] |-> (wordCtrl[POS_WFR] == !wordCtrl[POS_EDGE]));

  // R8: fractional mode implies the power word
  assert_power_frac_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordCtrl[POS_FEN] |-> (wordPower == WORD_W'(POWER_FRAC)));

endmodule

// File: rtl/fdivFieldEnc.sv
module fdivFieldEnc
  import fdiv_enc_pkg::*;
#(
  parameter int unsigned INT_W   = 8,
  parameter int unsigned FRAC_W  = 3,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned MAX_DIV = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [INT_W+FRAC_W-1:0] divIn,
  output logic                    outValid,
  output logic                    errOut,
  output logic [WORD_W-1:0]       wordHiLo,
  output logic [WORD_W-1:0]       wordCtrl,
  output logic [WORD_W-1:0]       wordPhase,
  output logic [WORD_W-1:0]       wordPower
);

  ctlStrb_t strb;

  fdivEncCtrl #(
    .INT_W  (INT_W),
    .MAX_DIV(MAX_DIV)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .intPart (divIn[FRAC_W +: INT_W]),
    .strb    (strb),
    .outValid(outValid),
    .errOut  (errOut)
  );

  fdivEncPath #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W),
    .CNT_W (CNT_W),
    .WORD_W(WORD_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .divIn    (divIn),
    .wordHiLo (wordHiLo),
    .wordCtrl (wordCtrl),
    .wordPhase(wordPhase),
    .wordPower(wordPower)
  );

endmodule

// File: tb/tb_fdivFieldEnc.sv
module tb_fdivFieldEnc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [10:0] divIn = '0;
  logic        outValid;
  logic        errOut;
  logic [15:0] wordHiLo;
  logic [15:0] wordCtrl;
  logic [15:0] wordPhase;
  logic [15:0] wordPower;

  int checks = 0;
  int fails  = 0;
  logic [63:0] lastExp = '0;

  always #5 clk = ~clk;

  fdivFieldEnc dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .divIn(divIn),
    .outValid(outValid), .errOut(errOut),
    .wordHiLo(wordHiLo), .wordCtrl(wordCtrl),
    .wordPhase(wordPhase), .wordPower(wordPower)
  );

  // Expected {hilo, ctrl, phase, power} from the requirements
  function automatic logic [63:0] model(input int ip, input int fr);
    int hi = 0, lo = 0, ed = 0, nc = 0, fe = 0, wr = 0, wf = 0, ph = 0;
    int hilo, ctrl, phw, pw;
    if (ip == 1) nc = 1;
    else if (fr == 0) begin
      hi = ip / 2; ed = ip % 2; lo = ip - hi;
    end else begin
      fe = 1; hi = ip / 2; ed = ip % 2; lo = hi;
      if (ed == 0) begin hi = hi - 1; wr = 1; end
      if (ed == 0 || fr == 1) lo = lo - 1;
      wf = (((ed == 0) != (fr == 1)) || (ip == 2 && fr == 1)) ? 1 : 0;
      ph = ed * 4 + fr / 2;
    end
    hilo = ((hi % 64) << 6) | (lo % 64);
    ctrl = ((fe ? fr : 0) << 12) | (fe << 11) | (wr << 10) | (ed << 7) | (nc << 6);
    phw  = (ph << 11) | (wf << 10);
    pw   = (fr != 0) ? 32'h9800 : 0;
    return {16'(hilo), 16'(ctrl), 16'(phw), 16'(pw)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic chkWords(input logic [63:0] e);
    chk("R1 R3 R5 R9 hilo", wordHiLo, e[63:48]);
    chk("R4 R7 ctrl", wordCtrl, e[47:32]);
    chk("R6 phase", wordPhase, e[31:16]);
    chk("R8 power", wordPower, e[15:0]);
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic apply(input int ip, input int fr);
    bit good = (ip >= 1 && ip <= 128);
    @(negedge clk);
    inValid = 1'b1;
    divIn   = 11'((ip << 3) | fr);
    @(negedge clk);
    inValid = 1'b0;
    if (good) begin
      lastExp = model(ip, fr);
      chk("R11 valid", {15'd0, outValid}, 16'd1);
      chk("R10 no err", {15'd0, errOut}, 16'd0);
    end else begin
      chk("R10 err", {15'd0, errOut}, 16'd1);
      chk("R10 no valid", {15'd0, outValid}, 16'd0);
    end
    chkWords(lastExp);
    @(negedge clk);
    chk("R11 pulse", {14'd0, outValid, errOut}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11: reset state
    chkWords('0);
    chk("R11 reset flags", {14'd0, outValid, errOut}, 16'd0);
    rstN = 1'b1;

    // Directed corners
    apply(1, 0);
    chk("R2 bypass ctrl", wordCtrl, 16'h0040);
    apply(1, 5);     // R2 with fraction; R8 power still set
    chk("R2 bypass hilo", wordHiLo, 16'h0000);
    apply(2, 0);
    apply(2, 1);     // R6 special case
    apply(3, 1);
    apply(4, 5);
    apply(5, 7);
    apply(6, 2);
    apply(127, 3);
    apply(128, 0);   // R9 wrap
    chk("R9 wrap", wordHiLo, 16'h0000);
    apply(128, 7);
    apply(0, 3);     // R10
    apply(129, 0);
    apply(255, 7);

    // Constrained random with idle gaps
    for (int i = 0; i < 400; i++) begin
      int ip = (($urandom % 8) == 0) ? int'($urandom_range(129, 255)) * int'($urandom % 2)
                                     : int'($urandom_range(1, 128));
      int fr = int'($urandom % 8);
      apply(ip, fr);
      repeat ($urandom % 4) @(negedge clk);
      chkWords(lastExp);   // R11 hold
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule